// File: doc/BRIEF.md
# Dual-Source Interrupt and Wake Controller

This block sits beside a small processor core. It chooses between two interrupt sources, starts their service and handles wake-up from the low-power halt state. The first source is a timer-overflow flag that is kept outside the block. The second is a periodic real-time tick. The block makes this tick by counting enables of a 32768 Hz reference, and a rate select sets the divide ratio. When a source wins, the block pulses a take strobe for one cycle together with a vector code. The core turns that code into a call. For a timer take, the block also pulses a clear strobe so that the timer flag is reset. The real-time pending latch is held inside the block, and the block clears it itself.

Service is held back in four cases:
- interrupts are disabled;
- the core reports that a plain subroutine is running;
- an earlier service has not yet returned;
- a halt is being requested or is in progress.

When both sources are pending, the real-time source always goes first.

During halt, two things can wake the core: a real-time tick, or a falling edge on any of eight synchronised input pins whose wake mask bit is set. If interrupts are disabled when the core wakes, the real-time request stays pending until interrupts are enabled. If they are enabled, the request is serviced straight after the wake.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the following are all 0: `irqTake`, `irqVec`, `timerClr`, `halted` and `wakePulse`. Interrupts start disabled.
- R2: The real-time tick fires on the enable of `tick32k` that brings the enable count to 128·2^`rateSel` (256/2^n Hz from a 32768 Hz reference). The count then restarts. The tick sets a pending latch whether or not interrupts are enabled. A tick that arrives while the latch is already set merges into it, so only one request remains.
- R3: A take is a one-cycle pulse of `irqTake`, registered one clock after the conditions for service hold. During that pulse `irqVec` is 8 for a real-time take and 4 for a timer take. At all other times `irqVec` is 0.
- R4: If the real-time latch and `timerFlag` are both set in the cycle a take is decided, the take uses vector 8. This holds whatever order the two arrived in.
- R5: No take is started while any of these hold: interrupts are disabled; `subActive` is high; an earlier take has had no `retStb` since; `haltReq` or `halted` is high. `eiStb` enables interrupts from the next cycle. `diStb` disables them, and it wins over `eiStb` when both come together.
- R6: A timer take pulses `timerClr` in the same cycle as `irqTake`. A real-time take clears the pending latch and does not pulse `timerClr`.
- R7: `haltReq` while not halted sets `halted` on the next clock. `haltReq` while already halted has no effect.
- R8: While halted, a real-time tick clears `halted` and pulses `wakePulse` for one cycle, both on the clock of the tick. If interrupts are disabled, the real-time request stays pending and is taken only after `eiStb`. If they are enabled, it is taken on the clock after the wake.
- R9: Each bit of `pinIn` passes through two synchronising flops (their reset value is 1). A 1-to-0 change on a bit whose `wakeMask` bit is 1 wakes a halted core on the third clock after the change. A change on a bit whose mask bit is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| rateSel | input | 3 | Real-time rate select n (divide by 128·2^n) |
| timerFlag | input | 1 | Timer overflow flag, held outside the block |
| eiStb | input | 1 | Enable-interrupt strobe |
| diStb | input | 1 | Disable-interrupt strobe |
| subActive | input | 1 | High while the core runs a plain subroutine |
| retStb | input | 1 | Return-from-service strobe |
| haltReq | input | 1 | Request to enter halt |
| pinIn | input | 8 | Asynchronous input pins |
| wakeMask | input | 8 | Per-pin wake enable |
| irqTake | output | 1 | One-cycle service start pulse |
| irqVec | output | 4 | Vector code (8 real-time, 4 timer, 0 otherwise) |
| timerClr | output | 1 | Pulse that clears the external timer flag |
| halted | output | 1 | Core is halted |
| wakePulse | output | 1 | One-cycle wake indication |

## Verification
Each result has a fixed latency, counted in register stages:
- A take, its vector and the timer clear appear one clock after their conditions hold.
- A real-time tick sets the pending latch on its own clock, so a take follows one clock later.
- The halt state changes on the clock after the request.
- A pin fall shows up as a wake on the third clock, because of the two synchroniser flops and the edge flop.

The bench drives inputs at the falling edge and advances a cycle model of the requirements by exactly one step at each rising edge. It then compares every output at the next falling edge, so each expectation is checked in the cycle it is due. Directed segments cover the divider period, merged ticks, simultaneous requests, masked and unmasked pins, and wake with interrupts enabled and disabled.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam int VEC_W = 4;
  localparam logic [VEC_W-1:0] VEC_RTC = 4'd8;
  localparam logic [VEC_W-1:0] VEC_TMR = 4'd4;

  typedef struct packed {
    logic rtcClr;
  } ctlStrobe_t;
endpackage

// File: rtl/irqw_datapath.sv
module irqw_datapath #(
  parameter int BASE_DIV = 128,
  parameter int SEL_W    = 3,
  parameter int NPINS    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick32k,
  input  logic [SEL_W-1:0]      rateSel,
  input  logic [NPINS-1:0]      pinIn,
  input  logic [NPINS-1:0]      wakeMask,
  input  irqw_pkg::ctlStrobe_t  strobes,
  output logic                  rtcTick,
  output logic                  rtcPend,
  output logic                  pinWake
);
  localparam int MAX_SEL = (1 << SEL_W) - 1;
  localparam int CNT_W   = $clog2(BASE_DIV << MAX_SEL);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W:0]   divLim;

  assign divLim  = (CNT_W+1)'(BASE_DIV) << rateSel;
  assign rtcTick = tick32k && ({1'b0, divCnt} >= divLim - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)        divCnt <= '0;
    else if (rtcTick) divCnt <= '0;
    else if (tick32k) divCnt <= divCnt + 1'b1;
  end

  // a new tick wins over a clear in the same cycle, so it is never lost
  always_ff @(posedge clk) begin
    if (!rstN) rtcPend <= 1'b0;
    else       rtcPend <= (rtcPend && !strobes.rtcClr) || rtcTick;
  end

  logic [NPINS-1:0] syncA, syncB, pinPrev, pinFall;

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_pin
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA[gi]   <= 1'b1;
          syncB[gi]   <= 1'b1;
          pinPrev[gi] <= 1'b1;
        end else begin
          syncA[gi]   <= pinIn[gi];
          syncB[gi]   <= syncA[gi];
          pinPrev[gi] <= syncB[gi];
        end
      end
      assign pinFall[gi] = pinPrev[gi] && !syncB[gi] && wakeMask[gi];
    end
  endgenerate

  assign pinWake = |pinFall;

  // R2
  tick_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtcTick |=> rtcPend);
  // R2
  pend_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rtcPend && !strobes.rtcClr) |=> rtcPend);
endmodule

// File: rtl/irqw_control.sv
module irqw_control (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          timerFlag,
  input  logic                          eiStb,
  input  logic                          diStb,
  input  logic                          subActive,
  input  logic                          retStb,
  input  logic                          haltReq,
  input  logic                          rtcTick,
  input  logic                          rtcPend,
  input  logic                          pinWake,
  output irqw_pkg::ctlStrobe_t          strobes,
  output logic                          irqTake,
  output logic [irqw_pkg::VEC_W-1:0]    irqVec,
  output logic                          timerClr,
  output logic                          halted,
  output logic                          wakePulse
);
  import irqw_pkg::*;

  logic intEn, inService, serve, wakeNow;

  assign serve   = intEn && !subActive && !inService && !halted && !haltReq
                   && (rtcPend || timerFlag);
  assign wakeNow = halted && (rtcTick || pinWake);
  assign strobes.rtcClr = serve && rtcPend;

  always_ff @(posedge clk) begin
    if (!rstN)      intEn <= 1'b0;
    else if (diStb) intEn <= 1'b0;
    else if (eiStb) intEn <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       inService <= 1'b0;
    else if (serve)  inService <= 1'b1;
    else if (retStb) inService <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqTake  <= 1'b0;
      irqVec   <= '0;
      timerClr <= 1'b0;
    end else begin
      irqTake  <= serve;
      irqVec   <= !serve ? '0 : (rtcPend ? VEC_RTC : VEC_TMR);
      timerClr <= serve && !rtcPend && timerFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halted    <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= wakeNow;
      if (halted) halted <= !wakeNow;
      else        halted <= haltReq;
    end
  end

  // R3
  take_is_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |=> !irqTake);
  // R4
  rtc_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqTake && irqVec == VEC_TMR) |-> !$past(rtcPend));
  // R6
  clr_only_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerClr |-> (irqTake && irqVec == VEC_TMR));
  // R7
  no_take_halted_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !irqTake);
  // R8
  wake_leaves_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!halted && $past(halted)));
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl #(
  parameter int BASE_DIV = 128,
  parameter int SEL_W    = 3,
  parameter int NPINS    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick32k,
  input  logic [SEL_W-1:0] rateSel,
  input  logic             timerFlag,
  input  logic             eiStb,
  input  logic             diStb,
  input  logic             subActive,
  input  logic             retStb,
  input  logic             haltReq,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] wakeMask,
  output logic             irqTake,
  output logic [3:0]       irqVec,
  output logic             timerClr,
  output logic             halted,
  output logic             wakePulse
);
  irqw_pkg::ctlStrobe_t strobes;
  logic rtcTick, rtcPend, pinWake;

  irqw_datapath #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W), .NPINS(NPINS)) u_dp (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .rateSel(rateSel),
    .pinIn(pinIn), .wakeMask(wakeMask), .strobes(strobes),
    .rtcTick(rtcTick), .rtcPend(rtcPend), .pinWake(pinWake)
  );

  irqw_control u_ctl (
    .clk(clk), .rstN(rstN), .timerFlag(timerFlag), .eiStb(eiStb),
    .diStb(diStb), .subActive(subActive), .retStb(retStb),
    .haltReq(haltReq), .rtcTick(rtcTick), .rtcPend(rtcPend),
    .pinWake(pinWake), .strobes(strobes), .irqTake(irqTake),
    .irqVec(irqVec), .timerClr(timerClr), .halted(halted),
    .wakePulse(wakePulse)
  );
endmodule

// File: tb/sim_irq_wake_ctrl.sv
module sim_irq_wake_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick32k = 1'b0;
  logic [2:0] rateSel = 3'd0;
  logic timerFlag = 1'b0, eiStb = 1'b0, diStb = 1'b0, subActive = 1'b0;
  logic retStb = 1'b0, haltReq = 1'b0;
  logic [7:0] pinIn = 8'hFF, wakeMask = 8'h00;
  logic irqTake, timerClr, halted, wakePulse;
  logic [3:0] irqVec;

  always #4 clk = ~clk;

  irq_wake_ctrl u0 (.*);

  int nVec = 0, nBad = 0, cycles = 0, takes = 0;

  // cycle model of the requirements
  int mCnt;
  bit mPend, mIe, mSvc, mHalt, mTake, mClr, mWake;
  logic [3:0] mVec;
  logic [7:0] mS1, mS2, mS3;

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  task automatic modelReset();
    mCnt = 0; mPend = 0; mIe = 0; mSvc = 0; mHalt = 0;
    mTake = 0; mClr = 0; mWake = 0; mVec = 0;
    mS1 = 8'hFF; mS2 = 8'hFF; mS3 = 8'hFF;
  endtask

  task automatic modelStep();
    int lim;
    bit tickEv, wakeNow, serve;
    lim = 128 << rateSel;
    tickEv  = tick32k && (mCnt >= lim - 1);
    wakeNow = mHalt && (tickEv || ((mS3 & ~mS2 & wakeMask) != 0));
    serve   = mIe && !subActive && !mSvc && !mHalt && !haltReq && (mPend || timerFlag);
    mTake = serve;
    mVec  = serve ? (mPend ? 4'd8 : 4'd4) : 4'd0;
    mClr  = serve && !mPend && timerFlag;
    mPend = (mPend && !(serve && mPend)) || tickEv;
    if (serve) mSvc = 1; else if (retStb) mSvc = 0;
    if (diStb) mIe = 0; else if (eiStb) mIe = 1;
    mWake = wakeNow;
    mHalt = mHalt ? !wakeNow : haltReq;
    mS3 = mS2; mS2 = mS1; mS1 = pinIn;
    if (tickEv) mCnt = 0; else if (tick32k) mCnt++;
  endtask

  // one clock: inputs already set at negedge, step model, compare at next negedge
  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    if (irqTake) takes++;
    chk({3'b0, irqTake},  {3'b0, mTake}, "R3 irqTake");
    chk(irqVec,           mVec,          "R4 irqVec");
    chk({3'b0, timerClr}, {3'b0, mClr},  "R6 timerClr");
    chk({3'b0, halted},   {3'b0, mHalt}, "R7 halted");
    chk({3'b0, wakePulse},{3'b0, mWake}, "R8 wakePulse");
    if (timerClr) timerFlag = 1'b0;
    eiStb = 0; diStb = 0; retStb = 0; haltReq = 0;
  endtask

  task automatic doReset();
    rstN = 0; tick32k = 0; eiStb = 0; diStb = 0; retStb = 0; haltReq = 0;
    subActive = 0; timerFlag = 0; pinIn = 8'hFF; wakeMask = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    modelReset();
    // R1: reset state
    chk({3'b0, irqTake}, 4'd0, "R1 irqTake");
    chk(irqVec, 4'd0, "R1 irqVec");
    chk({3'b0, halted}, 4'd0, "R1 halted");
    chk({3'b0, wakePulse}, 4'd0, "R1 wakePulse");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();

    // R5: ticks with interrupts disabled produce no take
    tick32k = 1; rateSel = 0; takes = 0;
    repeat (300) cyc();
    chk(takes[3:0], 4'd0, "R5 no take while disabled");
    // R2: merged ticks -> a single take once enabled
    tick32k = 0; eiStb = 1; cyc(); takes = 0;
    repeat (5) cyc();
    chk(takes[3:0], 4'd1, "R2 merged ticks one take");
    retStb = 1; cyc();

    // R2: divider period, sel 0 -> one take per 128 enables
    doReset();
    eiStb = 1; cyc();
    tick32k = 1; takes = 0;
    for (int i = 0; i < 1290; i++) begin
      if (irqTake) retStb = 1;
      cyc();
    end
    chk(takes[3:0], 4'd10, "R2 period count");

    // R4: timer and RTC together -> vector 8 first, timer after return
    doReset();
    eiStb = 1; subActive = 1; cyc();
    tick32k = 1; repeat (128) cyc(); tick32k = 0;
    timerFlag = 1; repeat (3) cyc();
    subActive = 0; cyc();
    chk(irqVec, 4'd8, "R4 rtc before timer");
    retStb = 1; cyc(); cyc();
    chk(irqVec, 4'd4, "R6 timer after rtc");

    // R8: wake by RTC with interrupts disabled, then EI services it
    doReset();
    haltReq = 1; cyc();
    tick32k = 1; repeat (128) cyc(); tick32k = 0;
    chk({3'b0, halted}, 4'd0, "R8 woke on tick");
    repeat (4) cyc();
    eiStb = 1; cyc(); cyc();
    chk(irqVec, 4'd8, "R8 held rtc served after enable");
    retStb = 1; cyc();

    // R9: masked pin ignored, unmasked pin fall wakes on third clock
    doReset();
    haltReq = 1; cyc();
    wakeMask = 8'h01; pinIn = 8'hFD; repeat (5) cyc();
    chk({3'b0, halted}, 4'd1, "R9 masked pin ignored");
    pinIn = 8'hFC; cyc(); cyc();
    chk({3'b0, halted}, 4'd1, "R9 not yet");
    cyc();
    chk({3'b0, wakePulse}, 4'd1, "R9 wake on third clock");

    // R7: halt ignored-while-halted and random mix against the model
    for (int seg = 0; seg < 6; seg++) begin
      doReset();
      rateSel = 3'($urandom_range(0, 1));
      wakeMask = 8'($urandom);
      for (int i = 0; i < 4000; i++) begin
        tick32k   = ($urandom_range(0, 3) != 0);
        eiStb     = ($urandom_range(0, 40) == 0);
        diStb     = ($urandom_range(0, 60) == 0);
        retStb    = ($urandom_range(0, 6) == 0);
        haltReq   = ($urandom_range(0, 150) == 0);
        if ($urandom_range(0, 30) == 0) subActive = ~subActive;
        if ($urandom_range(0, 50) == 0) timerFlag = 1;
        if ($urandom_range(0, 20) == 0) pinIn = 8'($urandom);
        cyc();
      end
    end

    // R2: slowest rate, sel 7 -> first tick after 16384 enables
    doReset();
    rateSel = 3'd7; eiStb = 1; cyc();
    tick32k = 1; takes = 0;
    repeat (16385) cyc();
    chk(takes[3:0], 4'd1, "R2 slowest rate");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule